// File: doc/BRIEF.md
# Two-Phase Non-Overlapping Switch Clock Generator

This block makes the control phases for a switched-capacitor stage from one fast reference clock. A tick counter divides each output period into a programmable number of reference ticks. The first half of the period belongs to phase one and the second half to phase two. Each main phase rises a programmable dead time after the start of its half and falls at the end of its half. The two main phases are therefore never high together, and at least one tick separates them on each handover.

Each main phase also has an early copy. The early copy rises together with its main phase and falls a programmable number of ticks before it. This lets the sampling switch open before the main switches, as bottom-plate sampling needs. The period, the dead time and the advance are read only at period boundaries, so a change never cuts a phase short.

Top module: `twophase_clkgen`

## Requirements
- R1: While `rst_n` is low, all four phase outputs are low. The first period after release starts at tick 0, and at that tick every output is low.
- R2: `phi1` and `phi2` are never high in the same cycle, and neither one rises in the cycle where the other falls.
- R3: With effective period P, half H = P/2 and dead time D, `phi1` is high for the ticks t with D <= t <= H-1 of each period, where tick 0 is the first tick after a wrap.
- R4: With advance A, `phi1_adv` is high for the ticks t with D <= t and t+A <= H-1. It falls at least one cycle before `phi1` falls.
- R5: `phi2` is high for the ticks t with H+D <= t <= P-1.
- R6: `phi2_adv` is high for the ticks t with H+D <= t and t+A <= P-1.
- R7: An early phase is high only while its main phase is high, so it never rises before its main phase.
- R8: New values on `period`, `dead` and `adv` take effect only at the first tick of the next period. The settings in force at tick P-1 govern the whole period that ends there.
- R9: The LSB of `period` is ignored. An even period below 4 is treated as 4, and a value of 0 on `dead` or `adv` is treated as 1.
- R10: When A leaves no tick for it, an early phase stays low for the whole period, while its main phase still runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock; one tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| period | input | CNT_W | Output period in ticks (LSB ignored, minimum 4) |
| dead | input | CNT_W | Dead time in ticks before each main phase rises (minimum 1) |
| adv | input | CNT_W | Ticks by which each early phase falls before its main phase (minimum 1) |
| phi1 | output | 1 | Main phase of the first half period |
| phi2 | output | 1 | Main phase of the second half period |
| phi1_adv | output | 1 | Early-falling copy of `phi1` |
| phi2_adv | output | 1 | Early-falling copy of `phi2` |

## Verification
Each output is registered from the tick count, so the level for tick t is visible one clock after the counter holds t. The bench keeps its own tick model on the rising edge. The model computes the expected level for the current tick before it advances, and the outputs are compared at the next falling edge. New settings are driven at a falling edge in the middle of a period, so the model and the design both adopt them at the same wrap. A reset is checked at the falling edge after the first reset edge, and the release is checked by comparing the outputs of the whole first period with the model.

// File: rtl/twophase_clkgen.sv
module twophase_clkgen #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] dead,
  input  logic [CNT_W-1:0] adv,
  output logic             phi1,
  output logic             phi2,
  output logic             phi1_adv,
  output logic             phi2_adv
);
  localparam int XW = CNT_W + 1;
  localparam logic [CNT_W-1:0] MIN_P = CNT_W'(4);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] cnt, p_q, d_q, a_q;

  wire [CNT_W-1:0] p_even = {period[CNT_W-1:1], 1'b0};
  wire [CNT_W-1:0] p_new  = (p_even < MIN_P) ? MIN_P : p_even;
  wire [CNT_W-1:0] d_new  = (dead == '0) ? ONE : dead;
  wire [CNT_W-1:0] a_new  = (adv == '0) ? ONE : adv;

  wire [XW-1:0] half  = XW'(p_q >> 1);
  wire [XW-1:0] cnt_x = XW'(cnt);
  wire          first = cnt_x < half;
  wire [XW-1:0] pos   = first ? cnt_x : cnt_x - half;
  wire          on_m  = pos >= XW'(d_q);
  wire          on_e  = on_m && ((pos + XW'(a_q)) < half);
  wire          wrap  = cnt == (p_q - ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      p_q      <= p_new;
      d_q      <= d_new;
      a_q      <= a_new;
      phi1     <= 1'b0;
      phi2     <= 1'b0;
      phi1_adv <= 1'b0;
      phi2_adv <= 1'b0;
    end else begin
      cnt      <= wrap ? '0 : cnt + ONE;
      if (wrap) begin
        p_q <= p_new;
        d_q <= d_new;
        a_q <= a_new;
      end
      phi1     <= first && on_m;
      phi2     <= !first && on_m;
      phi1_adv <= first && on_e;
      phi2_adv <= !first && on_e;
    end
  end
endmodule

// File: rtl/twophase_clkgen_chk.sv
module twophase_clkgen_chk (
  input logic clk,
  input logic rst_n,
  input logic phi1,
  input logic phi2,
  input logic phi1_adv,
  input logic phi2_adv
);
  a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !(phi1 || phi2 || phi1_adv || phi2_adv));

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(phi1 && phi2));

  a_r2_gap_1to2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phi1) |-> !phi2);

  a_r2_gap_2to1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phi2) |-> !phi1);

  a_r4_early_leads: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phi1) |-> !$past(phi1_adv));

  a_r6_early_leads: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phi2) |-> !$past(phi2_adv));

  a_r7_inside_1: assert property (@(posedge clk) disable iff (!rst_n)
    phi1_adv |-> phi1);

  a_r7_inside_2: assert property (@(posedge clk) disable iff (!rst_n)
    phi2_adv |-> phi2);
endmodule

bind twophase_clkgen twophase_clkgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phi1(phi1), .phi2(phi2),
  .phi1_adv(phi1_adv), .phi2_adv(phi2_adv)
);

// File: tb/twophase_clkgen_tb.sv
module twophase_clkgen_tb;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] period = 8'd16, dead = 8'd2, adv = 8'd1;
  logic phi1, phi2, phi1_adv, phi2_adv;
  int checks = 0, fails = 0, cycles = 0;

  int mt, mp, md, ma;
  logic e1, e2, e1a, e2a;

  always #4 clk = ~clk;

  twophase_clkgen #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .period(period), .dead(dead), .adv(adv),
    .phi1(phi1), .phi2(phi2), .phi1_adv(phi1_adv), .phi2_adv(phi2_adv)
  );

  task automatic load_model();
    int pe;
    pe = int'(period) & ~1;
    mp = (pe < 4) ? 4 : pe;
    md = (dead == 0) ? 1 : int'(dead);
    ma = (adv == 0) ? 1 : int'(adv);
  endtask

  always @(posedge clk) begin
    int h;
    cycles++;
    if (!rst_n) begin
      mt = 0; load_model();
      e1 = 0; e2 = 0; e1a = 0; e2a = 0;
    end else begin
      h   = mp / 2;
      e1  = (mt >= md) && (mt <= h - 1);
      e1a = (mt >= md) && (mt + ma <= h - 1);
      e2  = (mt >= h + md) && (mt <= mp - 1);
      e2a = (mt >= h + md) && (mt + ma <= mp - 1);
      if (mt == mp - 1) begin mt = 0; load_model(); end
      else mt++;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", req, cycles, act, exp);
    end
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk({"R3 phi1 ", tag}, phi1, e1);
      chk({"R4 phi1_adv ", tag}, phi1_adv, e1a);
      chk({"R5 phi2 ", tag}, phi2, e2);
      chk({"R6 phi2_adv ", tag}, phi2_adv, e2a);
      chk({"R2 overlap ", tag}, phi1 && phi2, 1'b0);
      chk({"R7 early inside ", tag}, (phi1_adv && !phi1) || (phi2_adv && !phi2), 1'b0);
    end
  endtask

  task automatic set_cfg(input int p, input int d, input int a);
    period = CNT_W'(p); dead = CNT_W'(d); adv = CNT_W'(a);
  endtask

  task automatic t_reset(input int n);
    @(negedge clk); rst_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R1 reset", phi1 | phi2 | phi1_adv | phi2_adv, 1'b0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first tick", phi1 | phi2 | phi1_adv | phi2_adv, 1'b0);
  endtask

  task automatic t_pattern(input int p, input int d, input int a, input string tag);
    @(negedge clk); set_cfg(p, d, a);
    run(3 * p + 2 * 20, tag);
  endtask

  task automatic t_no_early();
    @(negedge clk); set_cfg(12, 1, 5);
    run(40, "R10 no early");
    begin
      int seen = 0;
      for (int i = 0; i < 24; i++) begin
        @(negedge clk);
        if (phi1_adv || phi2_adv) seen++;
      end
      checks++;
      if (seen != 0) begin
        fails++;
        $display("FAIL R10 early phase active: actual %0d expected 0", seen);
      end
    end
  endtask

  task automatic t_midchange();
    @(negedge clk); set_cfg(16, 2, 1);
    run(40, "R8 settle");
    run(5, "R8 before");
    set_cfg(8, 1, 1);
    run(48, "R8 after");
  endtask

  task automatic t_sanitize();
    @(negedge clk); set_cfg(7, 0, 0);
    run(40, "R9 odd/zero");
    set_cfg(2, 1, 1);
    run(30, "R9 small period");
  endtask

  initial begin
    t_reset(3);
    run(40, "R3 first");
    t_pattern(16, 2, 1, "p16 d2 a1");
    t_pattern(20, 3, 4, "p20 d3 a4");
    t_pattern(10, 1, 3, "p10 d1 a3");
    t_no_early();
    t_midchange();
    t_sanitize();
    t_reset(4);
    run(30, "R1 after rerun");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    fails++;
    $display("FAIL watchdog: actual run still busy, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule